// File: doc/BRIEF.md
# Shutdown controller with wake-up detection

This block holds a system in shutdown and releases it on a wake-up event. Software requests shutdown through a 32-bit register bus. The request takes effect only when the write carries the correct 8-bit key. While shutdown is held, the block watches three wake sources:

- two external wake pins, each with its own edge selection and debounce length;
- a request from the real-time clock, which can be enabled or disabled.

The first qualifying event drops the shutdown request and records its source in a status register. Software reads that register to find the cause of the wake-up.

Wake pins are asynchronous. Each passes through a two-flop synchronizer before edge detection. Debounce lengths are counted in ticks of a slow-clock strobe, which comes from outside the block. The real-time-clock request is treated as synchronous to the bus clock.

Top module: `pwrdown_ctl`

## Requirements
- R1: After reset, `shdn_req` is 0 and the mode and status registers (offsets 0x4 and 0x8) read 0.
- R2: A write to offset 0x0 with bits 31:24 = 0xA5 and bit 0 = 1 sets `shdn_req` from the next clock edge and clears every status bit.
- R3: A write to offset 0x0 whose bits 31:24 differ from 0xA5 has no effect: `shdn_req` and the status register keep their values.
- R4: Reads of offset 0x0 return 0.
- R5: The mode register keeps only bits 1:0, 7:4, 9:8, 15:12 and 17, so writing all ones reads back 0x0002F3F3. Writes to the status register are ignored.
- R6: Wake mode field encoding, per pin (bits 1:0 for pin 0, bits 9:8 for pin 1): 0 means the pin is ignored, 1 means a low-to-high change qualifies, 2 means high-to-low, and 3 means either change.
- R7: The debounce field (bits 7:4 for pin 0, bits 15:12 for pin 1) holds N. With N = 0 the wake fires on the synchronized edge itself. With N > 0 it fires on the Nth slow tick after the edge, provided the pin has not changed since.
- R8: If the pin changes in a way that does not qualify while debounce counting is under way, the pending detection is dropped. Only a fresh qualifying edge restarts it.
- R9: The real-time-clock request wakes the system only while mode bit 17 is 1. Such a wake sets status bit 17.
- R10: Wake events that occur while `shdn_req` is 0 change neither `shdn_req` nor the status register.
- R11: A wake event while `shdn_req` is 1 clears `shdn_req` and sets status bit 0 or 1 for the pin that caused it. Status bits then stay set until the next accepted shutdown command.
- R12: An accepted shutdown command in the same cycle as a wake event takes priority: `shdn_req` stays 1 and the status register reads 0.
- R13: Wake events from several sources in the same cycle all set their own status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| wake_pin | input | NUM_WAKE | Asynchronous wake-up pins |
| rtc_wake_req | input | 1 | Wake request from the real-time clock |
| shdn_req | output | 1 | Shutdown request to the power logic |

## Verification
An accepted shutdown command and a wake event can land on the same clock edge. The bench provokes this while already in shutdown, with the real-time-clock source enabled: it raises the clock request in the very cycle of a keyed control write. It judges the outcome by checking that `shdn_req` is still 1 and that status reads 0. A later request on its own then wakes the system, which shows the source was live. Two pins that fire in the same cycle are also checked, for their combined status value.

// File: rtl/pwrdown_pkg.sv
// Shared constants and types for the shutdown controller.
// Assumes byte offsets on the register bus and a fixed 32-bit data path.
package pwrdown_pkg;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_RISE = 2'd1,
        WK_FALL = 2'd2,
        WK_BOTH = 2'd3
    } wk_mode_e;

    localparam int          DATA_W   = 32;
    localparam logic [7:0]  SHDN_KEY = 8'hA5;
    localparam int          OFS_CTRL = 0;
    localparam int          OFS_MODE = 4;
    localparam int          OFS_STAT = 8;
    localparam int          RTC_BIT  = 17;
    localparam int          FIELD_STRIDE = 8;

endpackage

// File: rtl/pwrdown_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is promised.
module pwrdown_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;

endmodule

// File: rtl/pwrdown_wake_det.sv
// Edge qualifier and debounce counter for one synchronized wake pin.
// Emits a one-cycle fire pulse when a qualifying edge has held for the
// programmed number of slow ticks. Any non-qualifying change aborts a
// pending detection. Assumes lvl is already synchronous to clk.
module pwrdown_wake_det
    import pwrdown_pkg::*;
#(
    parameter int DBNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              slow_tick,
    input  wk_mode_e          mode,
    input  logic [DBNC_W-1:0] dbnc,
    output logic              fire
);

    logic              prev_q;
    logic              armed_q;
    logic [DBNC_W-1:0] cnt_q;
    logic              fire_q;
    logic              edge_seen;
    logic              qual;

    // Change detect against the previous sample, filtered by the mode.
    always_comb begin
        edge_seen = (lvl != prev_q);
        unique case (mode)
            WK_RISE: qual = edge_seen &&  lvl;
            WK_FALL: qual = edge_seen && !lvl;
            WK_BOTH: qual = edge_seen;
            default: qual = 1'b0;
        endcase
    end

    // Arm on a qualifying edge, count ticks, drop on a bounce.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fire_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            fire_q <= 1'b0;
            if (mode == WK_NONE) begin
                armed_q <= 1'b0;
            end else if (edge_seen) begin
                if (qual && dbnc == '0) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                end else if (qual) begin
                    armed_q <= 1'b1;
                    cnt_q   <= dbnc;
                end else begin
                    armed_q <= 1'b0;
                end
            end else if (armed_q && slow_tick) begin
                if (cnt_q == DBNC_W'(1)) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - DBNC_W'(1);
                end
            end
        end
    end

    assign fire = fire_q;

    // R6
    no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WK_NONE) |=> !fire);

    // R7
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_seen && !slow_tick) |=> !fire);

endmodule

// File: rtl/pwrdown_regs.sv
// Register file: keyed control register, masked mode register and a
// read port onto the status register held in the top. Reads are
// combinational in the strobe cycle. Assumes one access per strobe.
module pwrdown_regs
    import pwrdown_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_WAKE = 2,
    parameter int DBNC_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [DATA_W-1:0]                 status,
    output logic                              cmd_ok,
    output logic [NUM_WAKE-1:0][1:0]          wk_mode,
    output logic [NUM_WAKE-1:0][DBNC_W-1:0]   wk_dbnc,
    output logic                              rtc_en
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    function automatic logic [DATA_W-1:0] mk_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_WAKE; i++) begin
            m[FIELD_STRIDE*i +: 2]        = 2'b11;
            m[FIELD_STRIDE*i + 4 +: DBNC_W] = '1;
        end
        m[RTC_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] MODE_MASK = mk_mask();

    logic [DATA_W-1:0] mode_q;
    logic              wr_mode;

    // Decode a keyed shutdown command and a mode write.
    always_comb begin
        cmd_ok  = bus_sel && bus_we && (bus_addr == A_CTRL) &&
                  (bus_wdata[31:24] == SHDN_KEY) && bus_wdata[0];
        wr_mode = bus_sel && bus_we && (bus_addr == A_MODE);
    end

    // Mode register storage, implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= bus_wdata & MODE_MASK;
        end
    end

    // Split the mode register into per-source fields.
    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_fld
        assign wk_mode[g] = mode_q[FIELD_STRIDE*g +: 2];
        assign wk_dbnc[g] = mode_q[FIELD_STRIDE*g + 4 +: DBNC_W];
    end
    assign rtc_en = mode_q[RTC_BIT];

    // Read mux; control and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == A_MODE)      bus_rdata = mode_q;
            else if (bus_addr == A_STAT) bus_rdata = status;
        end
    end

    // R4
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == A_CTRL) |-> (bus_rdata == '0));

    // R5
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_addr == A_MODE) |=> $stable(mode_q));

endmodule

// File: rtl/pwrdown_ctl.sv
// Shutdown controller top. Holds the shutdown request, gathers wake
// events from the pin detectors and the real-time clock, and records
// the wake cause in a sticky status register. Assumes rtc_wake_req is
// synchronous to clk and slow_tick is a one-cycle strobe.
module pwrdown_ctl
    import pwrdown_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_WAKE = 2,
    parameter int DBNC_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                slow_tick,
    input  logic [NUM_WAKE-1:0] wake_pin,
    input  logic                rtc_wake_req,
    output logic                shdn_req
);

    logic [NUM_WAKE-1:0]            pin_sync;
    logic [NUM_WAKE-1:0]            pin_fire;
    logic [NUM_WAKE-1:0][1:0]       wk_mode;
    logic [NUM_WAKE-1:0][DBNC_W-1:0] wk_dbnc;
    logic                           rtc_en;
    logic                           rtc_fire;
    logic                           cmd_ok;
    logic [DATA_W-1:0]              wake_vec;
    logic [DATA_W-1:0]              status_q;
    logic                           shdn_q;

    pwrdown_sync #(.W(NUM_WAKE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wake_pin),
        .d_sync  (pin_sync)
    );

    pwrdown_regs #(
        .ADDR_W   (ADDR_W),
        .NUM_WAKE (NUM_WAKE),
        .DBNC_W   (DBNC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status_q),
        .cmd_ok    (cmd_ok),
        .wk_mode   (wk_mode),
        .wk_dbnc   (wk_dbnc),
        .rtc_en    (rtc_en)
    );

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_det
        pwrdown_wake_det #(.DBNC_W(DBNC_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (pin_sync[g]),
            .slow_tick (slow_tick),
            .mode      (wk_mode_e'(wk_mode[g])),
            .dbnc      (wk_dbnc[g]),
            .fire      (pin_fire[g])
        );
    end

    // Collect all wake sources at their status bit positions.
    always_comb begin
        rtc_fire = rtc_wake_req && rtc_en;
        wake_vec = '0;
        wake_vec[NUM_WAKE-1:0] = pin_fire;
        wake_vec[RTC_BIT] = rtc_fire;
    end

    // Shutdown state and sticky cause; a keyed command has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shdn_q   <= 1'b0;
            status_q <= '0;
        end else if (cmd_ok) begin
            shdn_q   <= 1'b1;
            status_q <= '0;
        end else if (shdn_q && (wake_vec != '0)) begin
            shdn_q   <= 1'b0;
            status_q <= status_q | wake_vec;
        end
    end

    assign shdn_req = shdn_q;

    // R2
    cmd_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> (shdn_q && status_q == '0));

    // R10
    idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_q && !cmd_ok) |=> $stable(status_q) && !shdn_q);

    // R11
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdn_q) |-> (status_q != '0));

    // R9
    rtc_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_q && !cmd_ok && rtc_fire) |=> status_q[RTC_BIT]);

endmodule

// File: tb/sim_pwrdown_ctl.sv
// Scoreboard bench: driver tasks queue expected values, a monitor
// compares them against reads and the shutdown output.
module sim_pwrdown_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic [1:0]  wake_pin = '0;
    logic        rtc_wake_req = 1'b0;
    logic        shdn_req;
    logic        probe = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
        bit          is_shdn;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    pwrdown_ctl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .slow_tick    (slow_tick),
        .wake_pin     (wake_pin),
        .rtc_wake_req (rtc_wake_req),
        .shdn_req     (shdn_req)
    );

    // Monitor: pop an expectation whenever a read or probe is live.
    always begin
        @(negedge clk);
        #1;
        if ((bus_sel && !bus_we) || probe) begin
            item_t it;
            logic [31:0] act;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: queue empty, actual %h expected none", bus_rdata);
            end else begin
                it  = sb_q.pop_front();
                act = it.is_shdn ? {31'b0, shdn_req} : bus_rdata;
                n_cmp++;
                if (act !== it.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
                end
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
        sb_q.push_back('{val: e, tag: t, is_shdn: 1'b0});
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic shdn_chk(input logic e, input string t);
        sb_q.push_back('{val: {31'b0, e}, tag: t, is_shdn: 1'b1});
        @(negedge clk);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic pin(input int idx, input logic v);
        @(negedge clk);
        wake_pin[idx] = v;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    localparam logic [31:0] GO  = 32'hA500_0001;

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        // R1 reset state
        shdn_chk(1'b0, "R1 shdn after reset");
        rd_chk(4'h4, 32'h0, "R1 mode after reset");
        rd_chk(4'h8, 32'h0, "R1 status after reset");
        // R4 control reads zero
        rd_chk(4'h0, 32'h0, "R4 ctrl read");
        // R5 masking and status write ignored
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk(4'h4, 32'h0002_F3F3, "R5 mode mask");
        wr(4'h4, 32'h0);
        rd_chk(4'h4, 32'h0, "R5 mode cleared");
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk(4'h8, 32'h0, "R5 status write ignored");
        // R3 bad key
        wr(4'h0, 32'h5A00_0001);
        shdn_chk(1'b0, "R3 bad key no shutdown");
        // R10 wake while running is ignored
        wr(4'h4, 32'h0000_0001);
        pin(0, 1'b1); cyc(6);
        shdn_chk(1'b0, "R10 shdn unchanged");
        rd_chk(4'h8, 32'h0, "R10 status unchanged");
        pin(0, 1'b0); cyc(6);
        // R2 accepted command
        wr(4'h0, GO);
        shdn_chk(1'b1, "R2 shutdown entered");
        // R6 falling mode: rise ignored, fall wakes
        wr(4'h4, 32'h0000_0002);
        pin(0, 1'b1); cyc(6);
        shdn_chk(1'b1, "R6 rise ignored in fall mode");
        pin(0, 1'b0); cyc(6);
        shdn_chk(1'b0, "R6 fall wakes");
        rd_chk(4'h8, 32'h1, "R11 status pin0");
        cyc(5);
        rd_chk(4'h8, 32'h1, "R11 status sticky");
        // R3 bad key keeps status
        wr(4'h0, 32'h0000_0001);
        rd_chk(4'h8, 32'h1, "R3 bad key keeps status");
        shdn_chk(1'b0, "R3 bad key keeps shdn");
        wr(4'h0, GO);
        rd_chk(4'h8, 32'h0, "R2 status cleared");
        // R6 mode none ignores pin1
        wr(4'h4, 32'h0);
        pin(1, 1'b1); cyc(6);
        shdn_chk(1'b1, "R6 none ignores pin");
        pin(1, 1'b0); cyc(6);
        // R7 any edge with debounce 3 on pin1
        wr(4'h4, 32'h0000_3300);
        pin(1, 1'b1); cyc(4);
        tick(2);
        shdn_chk(1'b1, "R7 before third tick");
        tick(1); cyc(2);
        shdn_chk(1'b0, "R7 wake after third tick");
        rd_chk(4'h8, 32'h2, "R11 status pin1");
        // R8 bounce drops pending detection
        wr(4'h0, GO);
        wr(4'h4, 32'h0000_0021);
        pin(0, 1'b1); cyc(4);
        tick(1);
        pin(0, 1'b0); cyc(4);
        tick(2); cyc(2);
        shdn_chk(1'b1, "R8 bounce cancels");
        rd_chk(4'h8, 32'h0, "R8 no status");
        pin(0, 1'b1); cyc(4);
        tick(2); cyc(2);
        shdn_chk(1'b0, "R8 fresh edge wakes");
        rd_chk(4'h8, 32'h1, "R8 status pin0");
        // R9 rtc gated by enable
        wr(4'h0, GO);
        wr(4'h4, 32'h0);
        @(negedge clk); rtc_wake_req = 1'b1;
        cyc(2);
        rtc_wake_req = 1'b0;
        shdn_chk(1'b1, "R9 rtc disabled ignored");
        wr(4'h4, 32'h0002_0000);
        @(negedge clk); rtc_wake_req = 1'b1;
        @(negedge clk); rtc_wake_req = 1'b0;
        shdn_chk(1'b0, "R9 rtc wakes");
        rd_chk(4'h8, 32'h0002_0000, "R9 status rtc");
        // R12 command and wake in same cycle
        wr(4'h0, GO);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = GO;
        rtc_wake_req = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; rtc_wake_req = 1'b0;
        shdn_chk(1'b1, "R12 command wins");
        rd_chk(4'h8, 32'h0, "R12 status clear");
        @(negedge clk); rtc_wake_req = 1'b1;
        @(negedge clk); rtc_wake_req = 1'b0;
        shdn_chk(1'b0, "R12 rtc live afterwards");
        // R13 both pins in one cycle
        wr(4'h0, GO);
        wr(4'h4, 32'h0000_0303);
        @(negedge clk); wake_pin = 2'b00;
        cyc(6);
        shdn_chk(1'b0, "R13 dual wake");
        rd_chk(4'h8, 32'h3, "R13 both status bits");
        cyc(4);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        summary();
    end

endmodule